// File: doc/BRIEF.md
# Per-Requester Miss Stride Prefetcher

This block observes cache misses, each carrying a byte address and the identifier of the requester that caused it. For every requester it remembers the block addresses of the two most recent misses. When the distance from the previous miss to the current one is non-zero and equals the distance between the two misses before it, the stride counts as confirmed. The block then emits a short run of prefetch addresses that continue the stride past the current miss, one per cycle, through a valid/ready output.

Configuration inputs set the run length (one to eight addresses), whether a run must stay inside the page of the triggering miss, and whether all requesters share one history slot. When the page check cuts a run short, the addresses it discards are added to a running drop counter. The block does not look up the cache and does not filter repeated prefetches. It accepts no new miss while a run is still being emitted.

Top module: `stride_prefetcher`

## Requirements
- R1: A miss address is reduced to its block address by clearing its low log2(BLK_BYTES) bits before any stride arithmetic, and every prefetch address is block aligned.
- R2: Each accepted miss shifts the history of its slot, whether or not it triggers prefetches: the older entry takes the previous newest value and the newest entry takes the current block address. Slots of other requesters are unchanged.
- R3: When `cfg_shared_id` is 1, every miss uses slot 0 whatever its `miss_id`. When it is 0, the slot equals `miss_id`.
- R4: A run starts only when (current − newest) equals (newest − older), with both strides taken modulo 2^ADDR_W (signed), and that stride is non-zero. The run offers current + d×stride for d = 1 up to the degree, in increasing d. The degree is `cfg_degree` + 1, so field value 0 gives 1 and 7 gives 8.
- R5: With `cfg_page_stop` = 1, the run ends at the first candidate whose page (the address divided by PAGE_BYTES) differs from the page of the current miss. That candidate and every later one is not offered, and `drop_count` increases by degree − d + 1.
- R6: With `cfg_page_stop` = 0, all degree candidates are offered even across page boundaries, and `drop_count` does not change.
- R7: `miss_ready` is 0 from the cycle after a miss that starts a run until the run ends. A miss that starts no run leaves `miss_ready` at 1.
- R8: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` holds its value. A candidate advances only when it is taken.
- R9: After reset, every history entry is zero, `drop_count` is 0, `pf_valid` is 0 and `miss_ready` is 1.
- R10: The degree and the page-stop setting are sampled when the triggering miss is accepted. Changing them during a run does not change that run.
- R11: A matching zero stride produces no prefetch and does not change `drop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | The block can accept a miss |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_id | input | ID_W | Requester identifier of the miss |
| cfg_degree | input | DEG_W | Run length minus one |
| cfg_page_stop | input | 1 | Confine runs to the page of the miss |
| cfg_shared_id | input | 1 | All requesters share history slot 0 |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Downstream takes the offered address |
| pf_addr | output | ADDR_W | Prefetch byte address |
| drop_count | output | DROP_W | Running count of candidates discarded at page edges (wraps) |

## Verification
The assertions assume that `miss_valid` is only counted while `miss_ready` is high, and that `pf_ready` may change freely in any cycle. They also assume that configuration changes during a run are meant to have no effect. The stimulus keeps to this by raising `miss_valid` only when the block is idle and by dropping it after a single edge. It toggles `pf_ready` only in the back-pressure scenario and changes the degree in the middle of a run in one scenario. Expected runs come from a reference history kept in the bench, which uses multiplication and page division instead of the design's running adder.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_EMIT = 1'b1
  } run_state_e;

  function automatic int unsigned log2_exact(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/sp_history.sv
module sp_history #(
  parameter int ID_W  = 6,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  slot,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] last_tag,
  output logic [TAG_W-1:0] prev_tag
);
  localparam int NUM_SLOTS = 1 << ID_W;

  logic [TAG_W-1:0] last_q [NUM_SLOTS];
  logic [TAG_W-1:0] prev_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q[s] <= '0;
        prev_q[s] <= '0;
      end else if (wr_en && (slot == ID_W'(s))) begin
        prev_q[s] <= last_q[s];
        last_q[s] <= wr_tag;
      end
    end
  end

  assign last_tag = last_q[slot];
  assign prev_tag = prev_q[slot];

  // shadow of the last write, for checking the shift one cycle later
  logic             chk_wr;
  logic [ID_W-1:0]  chk_slot;
  logic [TAG_W-1:0] chk_new;
  logic [TAG_W-1:0] chk_old;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_wr   <= 1'b0;
      chk_slot <= '0;
      chk_new  <= '0;
      chk_old  <= '0;
    end else begin
      chk_wr   <= wr_en;
      chk_slot <= slot;
      chk_new  <= wr_tag;
      chk_old  <= last_tag;
    end
  end

  a_r2_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |-> (last_q[chk_slot] == chk_new) && (prev_q[chk_slot] == chk_old));

endmodule

// File: rtl/sp_detect.sv
module sp_detect #(
  parameter int ADDR_W = 32,
  parameter int BLK_LG = 6,
  localparam int TAG_W = ADDR_W - BLK_LG
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  last_tag,
  input  logic [TAG_W-1:0]  prev_tag,
  output logic [TAG_W-1:0]  cur_tag,
  output logic [TAG_W-1:0]  stride_tag,
  output logic              stride_hit
);
  function automatic logic [TAG_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_LG];
  endfunction

  function automatic logic [TAG_W-1:0] delta(input logic [TAG_W-1:0] to_tag,
                                             input logic [TAG_W-1:0] from_tag);
    return to_tag - from_tag;
  endfunction

  logic [TAG_W-1:0] fresh_stride;
  logic [TAG_W-1:0] older_stride;

  assign cur_tag      = block_of(addr);
  assign fresh_stride = delta(cur_tag, last_tag);
  assign older_stride = delta(last_tag, prev_tag);
  assign stride_tag   = fresh_stride;
  assign stride_hit   = (fresh_stride == older_stride) && (fresh_stride != '0);

endmodule

// File: rtl/sp_burst.sv
module sp_burst
  import sp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LG  = 6,
  parameter int PAGE_LG = 12,
  parameter int DEG_W   = 3,
  localparam int TAG_W  = ADDR_W - BLK_LG,
  localparam int AMT_W  = DEG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAG_W-1:0]  base_tag,
  input  logic [TAG_W-1:0]  stride_tag,
  input  logic [DEG_W-1:0]  deg_m1,
  input  logic              stop_en,
  input  logic              pf_ready,
  output logic              busy,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              drop_evt,
  output logic [AMT_W-1:0]  drop_amt
);
  localparam int PG_W = ADDR_W - PAGE_LG;

  function automatic logic [ADDR_W-1:0] to_bytes(input logic [TAG_W-1:0] t);
    return {t, {BLK_LG{1'b0}}};
  endfunction

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_LG];
  endfunction

  function automatic logic [AMT_W-1:0] remaining(input logic [DEG_W-1:0] last_idx,
                                                 input logic [DEG_W-1:0] idx);
    return {1'b0, last_idx} - {1'b0, idx} + AMT_W'(1);
  endfunction

  run_state_e       state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] cand_q;
  logic [DEG_W-1:0]  last_idx_q;
  logic [DEG_W-1:0]  idx_q;
  logic              stop_q;
  logic              crossed;
  logic              taken;
  logic              final_one;

  assign busy      = (state_q == RUN_EMIT);
  assign crossed   = busy && stop_q && (page_of(cand_q) != page_of(base_q));
  assign pf_valid  = busy && !crossed;
  assign pf_addr   = cand_q;
  assign taken     = pf_valid && pf_ready;
  assign final_one = (idx_q == last_idx_q);
  assign drop_evt  = crossed;
  assign drop_amt  = remaining(last_idx_q, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RUN_IDLE;
      base_q     <= '0;
      step_q     <= '0;
      cand_q     <= '0;
      last_idx_q <= '0;
      idx_q      <= '0;
      stop_q     <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        state_q    <= RUN_EMIT;
        base_q     <= to_bytes(base_tag);
        step_q     <= to_bytes(stride_tag);
        cand_q     <= to_bytes(base_tag + stride_tag);
        last_idx_q <= deg_m1;
        idx_q      <= '0;
        stop_q     <= stop_en;
      end
    end else if (crossed) begin
      state_q <= RUN_IDLE;
    end else if (taken) begin
      if (final_one) begin
        state_q <= RUN_IDLE;
      end else begin
        idx_q  <= idx_q + DEG_W'(1);
        cand_q <= cand_q + step_q;
      end
    end
  end

  a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_idx_q));

  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  a_r5_drop_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !busy);

  a_r1_offer_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[BLK_LG-1:0] == '0));

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 6,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_DEG    = 8,
  parameter int DROP_W     = 16,
  localparam int BLK_LG    = sp_pkg::log2_exact(BLK_BYTES),
  localparam int PAGE_LG   = sp_pkg::log2_exact(PAGE_BYTES),
  localparam int DEG_W     = sp_pkg::log2_exact(MAX_DEG),
  localparam int TAG_W     = ADDR_W - BLK_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ID_W-1:0]   miss_id,
  input  logic [DEG_W-1:0]  cfg_degree,
  input  logic              cfg_page_stop,
  input  logic              cfg_shared_id,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [DROP_W-1:0] drop_count
);
  logic [ID_W-1:0]  slot;
  logic             accept;
  logic             busy;
  logic [TAG_W-1:0] last_tag;
  logic [TAG_W-1:0] prev_tag;
  logic [TAG_W-1:0] cur_tag;
  logic [TAG_W-1:0] stride_tag;
  logic             stride_hit;
  logic             run_start;
  logic             drop_evt;
  logic [DEG_W:0]   drop_amt;
  logic [DROP_W-1:0] drop_q;

  assign slot       = cfg_shared_id ? '0 : miss_id;
  assign miss_ready = !busy;
  assign accept     = miss_valid && miss_ready;
  assign run_start  = accept && stride_hit;

  sp_history #(.ID_W(ID_W), .TAG_W(TAG_W)) u_history (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .slot     (slot),
    .wr_tag   (cur_tag),
    .last_tag (last_tag),
    .prev_tag (prev_tag)
  );

  sp_detect #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_detect (
    .addr       (miss_addr),
    .last_tag   (last_tag),
    .prev_tag   (prev_tag),
    .cur_tag    (cur_tag),
    .stride_tag (stride_tag),
    .stride_hit (stride_hit)
  );

  sp_burst #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG), .PAGE_LG(PAGE_LG), .DEG_W(DEG_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (run_start),
    .base_tag   (cur_tag),
    .stride_tag (stride_tag),
    .deg_m1     (cfg_degree),
    .stop_en    (cfg_page_stop),
    .pf_ready   (pf_ready),
    .busy       (busy),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr),
    .drop_evt   (drop_evt),
    .drop_amt   (drop_amt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= '0;
    else if (drop_evt) drop_q <= drop_q + DROP_W'(drop_amt);
  end

  assign drop_count = drop_q;

  a_r7_no_miss_during_run: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !miss_ready);

  a_r7_run_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !miss_ready);

  a_r5_drop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (drop_count != $past(drop_count)));

  a_r6_drop_still: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_count));

  a_r11_no_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cur_tag == last_tag)) |=> miss_ready);

endmodule

// File: tb/test_stride_prefetcher.sv
module test_stride_prefetcher;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic [5:0]    miss_id = '0;
  logic [2:0]    cfg_degree = 3'd3;
  logic          cfg_page_stop = 1'b0;
  logic          cfg_shared_id = 1'b0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [AW-1:0] pf_addr;
  logic [15:0]   drop_count;

  int errors = 0;
  int checks = 0;

  // bench reference state
  logic [AW-1:0] m_last [64];
  logic [AW-1:0] m_prev [64];
  logic [15:0]   m_drop = '0;
  logic [AW-1:0] exp_q [8];
  int            exp_n;
  logic [AW-1:0] got_q [16];
  int            got_n;

  always #4 clk = ~clk;

  stride_prefetcher i_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_id(miss_id), .cfg_degree(cfg_degree),
    .cfg_page_stop(cfg_page_stop), .cfg_shared_id(cfg_shared_id),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [AW-1:0] a, input int slot, input int deg, input bit stop);
    logic [AW-1:0] blk, ns, os, c;
    blk = a & ~32'h3F;
    ns = blk - m_last[slot];
    os = m_last[slot] - m_prev[slot];
    m_prev[slot] = m_last[slot];
    m_last[slot] = blk;
    exp_n = 0;
    if (ns == os && ns != 0) begin
      for (int d = 1; d <= deg; d++) begin
        c = blk + AW'(d) * ns;
        if (stop && (c / 4096) != (blk / 4096)) begin
          m_drop = m_drop + 16'(deg - d + 1);
          break;
        end
        exp_q[exp_n] = c;
        exp_n++;
      end
    end
  endtask

  // present one miss, collect the run it causes, compare with the model
  task automatic do_miss(input logic [AW-1:0] a, input logic [5:0] id, input string req,
                         input bit backpressure, input int late_degree);
    int slot;
    bit ph;
    slot = cfg_shared_id ? 0 : int'(id);
    model(a, slot, int'(cfg_degree) + 1, cfg_page_stop);
    @(negedge clk);
    chk(miss_ready == 1'b1, "R7 idle before miss", 64'(miss_ready), 64'd1);
    miss_valid = 1'b1;
    miss_addr = a;
    miss_id = id;
    @(negedge clk);
    miss_valid = 1'b0;
    if (late_degree >= 0) cfg_degree = 3'(late_degree);
    got_n = 0;
    ph = 1'b0;
    pf_ready = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (pf_valid) begin
        if (miss_ready) chk(1'b0, "R7 ready during run", 64'(miss_ready), 64'd0);
        if (pf_ready && got_n < 16) begin
          got_q[got_n] = pf_addr;
          got_n++;
        end
      end else if (miss_ready) begin
        break;
      end
      if (backpressure) begin
        ph = ~ph;
        pf_ready = ph;
      end
      @(negedge clk);
    end
    pf_ready = 1'b1;
    chk(got_n == exp_n, {req, " count"}, 64'(got_n), 64'(exp_n));
    for (int j = 0; j < exp_n && j < got_n; j++)
      chk(got_q[j] == exp_q[j], {req, " address"}, 64'(got_q[j]), 64'(exp_q[j]));
    chk(drop_count == m_drop, {req, " drops"}, 64'(drop_count), 64'(m_drop));
  endtask

  task automatic t_reset();
    chk(miss_ready == 1'b1, "R9 ready", 64'(miss_ready), 64'd1);
    chk(pf_valid == 1'b0, "R9 valid", 64'(pf_valid), 64'd0);
    chk(drop_count == 16'd0, "R9 drops", 64'(drop_count), 64'd0);
  endtask

  task automatic t_basic();
    cfg_degree = 3'd3; cfg_page_stop = 1'b0;
    do_miss(32'h1000_0000, 6'd3, "R9 first", 0, -1);
    do_miss(32'h1000_0040, 6'd3, "R2 second", 0, -1);
    do_miss(32'h1000_0080, 6'd3, "R4 run", 0, -1);
  endtask

  task automatic t_unaligned();
    cfg_degree = 3'd2;
    do_miss(32'h2000_0013, 6'd5, "R1 a", 0, -1);
    do_miss(32'h2000_00A7, 6'd5, "R1 b", 0, -1);
    do_miss(32'h2000_0105, 6'd5, "R1 run", 0, -1);
  endtask

  task automatic t_negative();
    cfg_degree = 3'd1;
    do_miss(32'h0400_0800, 6'd7, "R4 neg a", 0, -1);
    do_miss(32'h0400_0700, 6'd7, "R4 neg b", 0, -1);
    do_miss(32'h0400_0600, 6'd7, "R4 neg run", 0, -1);
  endtask

  task automatic t_interleave();
    cfg_degree = 3'd0;
    do_miss(32'h5000_0000, 6'd10, "R2 i10", 0, -1);
    do_miss(32'h6000_0000, 6'd11, "R2 i11", 0, -1);
    do_miss(32'h5000_0040, 6'd10, "R2 i10", 0, -1);
    do_miss(32'h6000_0200, 6'd11, "R2 i11", 0, -1);
    do_miss(32'h5000_0080, 6'd10, "R2 i10 run", 0, -1);
    do_miss(32'h6000_0400, 6'd11, "R2 i11 run", 0, -1);
  endtask

  task automatic t_shared();
    cfg_shared_id = 1'b1; cfg_degree = 3'd2;
    do_miss(32'h7000_0000, 6'd20, "R3 s", 0, -1);
    do_miss(32'h7000_00C0, 6'd21, "R3 s", 0, -1);
    do_miss(32'h7000_0180, 6'd22, "R3 shared run", 0, -1);
    cfg_shared_id = 1'b0;
    do_miss(32'h7000_0240, 6'd22, "R3 own slot", 0, -1);
  endtask

  task automatic t_page_stop();
    cfg_page_stop = 1'b1; cfg_degree = 3'd7;
    do_miss(32'h3000_0E00, 6'd30, "R5 a", 0, -1);
    do_miss(32'h3000_0E80, 6'd30, "R5 b", 0, -1);
    do_miss(32'h3000_0F00, 6'd30, "R5 cut", 0, -1);
    do_miss(32'h3000_0F80, 6'd30, "R5 cut first", 0, -1);
  endtask

  task automatic t_page_free();
    cfg_page_stop = 1'b0; cfg_degree = 3'd7;
    do_miss(32'h3100_0E00, 6'd31, "R6 a", 0, -1);
    do_miss(32'h3100_0E80, 6'd31, "R6 b", 0, -1);
    do_miss(32'h3100_0F00, 6'd31, "R6 across", 0, -1);
  endtask

  task automatic t_zero();
    cfg_degree = 3'd3;
    do_miss(32'h4400_0100, 6'd40, "R11 a", 0, -1);
    do_miss(32'h4400_0100, 6'd40, "R11 b", 0, -1);
    do_miss(32'h4400_0110, 6'd40, "R11 zero", 0, -1);
  endtask

  task automatic t_backpressure();
    cfg_degree = 3'd7;
    do_miss(32'h4500_0000, 6'd41, "R8 a", 0, -1);
    do_miss(32'h4500_0100, 6'd41, "R8 b", 0, -1);
    do_miss(32'h4500_0200, 6'd41, "R8 stalled", 1, -1);
  endtask

  task automatic t_late_degree();
    cfg_degree = 3'd1; cfg_page_stop = 1'b0;
    do_miss(32'h4600_0000, 6'd42, "R10 a", 0, -1);
    do_miss(32'h4600_0040, 6'd42, "R10 b", 0, -1);
    do_miss(32'h4600_0080, 6'd42, "R10 sampled", 0, 7);
    cfg_degree = 3'd1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 64; s++) begin
      m_last[s] = '0;
      m_prev[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_unaligned();
    t_negative();
    t_interleave();
    t_shared();
    t_page_stop();
    t_page_free();
    t_zero();
    t_backpressure();
    t_late_degree();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule